// File: doc/BRIEF.md
# Configurable Integer Multiply-Add Datapath

This block takes three 32-bit source words and returns one 32-bit result: the product of two fields picked out of the first two words, plus the third word. Each multiplier input first passes through a sub-word selector. The selector picks a byte, a halfword or the whole word, then sign- or zero-extends that field according to a per-operand signedness flag. The product is formed at full width. It can then be negated, or the addend can be negated instead. A plus-one mode adds an extra unit for rounding averages. The wide sum can be scaled down by an arithmetic right shift and clamped to the 32-bit range of its own signedness.

Whether the result is signed follows from the operand types and the negate flags. That one bit drives the extension of the addend, the fill of the shift and the clamp bounds. Negation is folded into the single wide adder as a bitwise invert plus a carry-in of one. Operands arrive on a valid/ready input that never stalls. Results leave two cycles later with a valid strobe. A forbidden combination, plus-one together with any negate, raises a flag and forces a zero result.

Top module: `imad_unit`

## Requirements
- R1: Select code values 0 to 3 pick byte 0 to 3 (bits 8k+7..8k), 4 picks bits 15..0, 5 picks bits 31..16, and 6 or 7 pick the whole word. The field is sign-extended when the operand's signed flag is 1 and zero-extended when it is 0.
- R2: The product is negated exactly when one and only one of `a_neg` and `b_neg` is 1. The sum is then c minus the product.
- R3: The result is signed when `a_signed` or `b_signed` is 1, when the product is negated, or when `c_neg` is 1. Otherwise it is unsigned. The addend is sign-extended from bit 31 for a signed result and zero-extended for an unsigned one.
- R4: With `c_neg` set and the product not negated, the sum is the product minus c. When the product is negated, `c_neg` does not change the sum.
- R5: With `plus_one` set and no negate flag, the sum is product plus c plus one.
- R6: `scale_mode` 1 shifts the wide sum right by 7 and 2 shifts it right by 15. Values 0 and 3 leave it unshifted. The shift fills with the sign for a signed result and with zeros for an unsigned one.
- R7: With `sat_en` set, a signed result is clamped to 0x80000000..0x7FFFFFFF and an unsigned result to at most 0xFFFFFFFF. With `sat_en` clear, the low 32 bits of the scaled sum are returned.
- R8: When `plus_one` is set together with any negate flag, `out_illegal` is 1 and `out_result` is 0 for that operation. Otherwise `out_illegal` is 0.
- R9: `in_ready` is always 1. Each operation accepted with `in_valid` at a clock edge gives `out_valid` high, with its result, after exactly two rising edges. `out_valid` is low in cycles that follow no accepted operation.
- R10: During reset, `out_valid`, `out_illegal` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Always 1; the pipeline never stalls |
| a_word | input | 32 | First multiplier source |
| b_word | input | 32 | Second multiplier source |
| c_word | input | 32 | Addend |
| a_signed | input | 1 | Selected field of a is signed |
| b_signed | input | 1 | Selected field of b is signed |
| a_sel | input | 3 | Sub-word select code for a |
| b_sel | input | 3 | Sub-word select code for b |
| a_neg | input | 1 | Negate flag on a |
| b_neg | input | 1 | Negate flag on b |
| c_neg | input | 1 | Negate the addend |
| plus_one | input | 1 | Add one to the sum |
| scale_mode | input | 2 | 0 none, 1 shift by 7, 2 shift by 15, 3 none |
| sat_en | input | 1 | Clamp to the 32-bit range |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Result word |
| out_illegal | output | 1 | Forbidden control combination |

## Verification
Every result and the illegal flag are due two rising edges after the edge that accepts the operation, and `out_valid` follows that same two-edge delay. The bench drives at falling edges and keeps a two-entry queue of expected outputs that shifts once per falling edge. Each falling edge compares the outputs with the entry queued two falling edges earlier, including idle slots that must show `out_valid` low. Back-to-back operations and random bubbles both go through this queue, so any added or missing pipeline stage shows up as a mismatch.

// File: rtl/imad_pkg.sv
package imad_pkg;
    parameter int unsigned DW   = 32;   // data word width
    parameter int unsigned WIDE = 72;   // internal sum width, > 2*(DW+1)
    parameter int unsigned SELW = 3;    // select code width
    parameter int unsigned SH_A = 7;    // first scale shift
    parameter int unsigned SH_B = 15;   // second scale shift

    localparam int unsigned XW = DW + 1;  // extended operand width

    typedef enum logic [1:0] {
        SCL_NONE = 2'd0,
        SCL_SHA  = 2'd1,
        SCL_SHB  = 2'd2,
        SCL_RSV  = 2'd3
    } scale_e;

    typedef struct packed {
        logic            vld;
        logic [WIDE-1:0] prod;
        logic [WIDE-1:0] addend;
        logic            neg_p;
        logic            neg_c;
        logic            po;
        logic            sgn;
        scale_e          scl;
        logic            sat;
        logic            bad;
    } s1_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic          bad;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;
endpackage

// File: rtl/imad_opsel.sv
module imad_opsel
    import imad_pkg::*;
(
    input  logic [DW-1:0]   word,
    input  logic            sgn,
    input  logic [SELW-1:0] sel,
    output logic [XW-1:0]   ext
);
    localparam int unsigned BW = DW / 4;
    localparam int unsigned HW = DW / 2;

    logic [BW-1:0] byte_f;
    logic [HW-1:0] half_f;

    always_comb begin
        byte_f = word[sel[1:0]*BW +: BW];
        half_f = word[sel[0]*HW +: HW];
        if (!sel[2]) begin
            ext = {{(XW-BW){sgn & byte_f[BW-1]}}, byte_f};
        end else if (!sel[1]) begin
            ext = {{(XW-HW){sgn & half_f[HW-1]}}, half_f};
        end else begin
            ext = {sgn & word[DW-1], word};
        end
    end
endmodule

// File: rtl/imad_finish.sv
module imad_finish
    import imad_pkg::*;
(
    input  s1_t           s1,
    output logic [DW-1:0] res
);
    logic [WIDE-1:0] term_p;
    logic [WIDE-1:0] term_c;
    logic [WIDE-1:0] sum;
    logic [WIDE-1:0] shd;
    logic            cin;
    logic            over;
    logic            under;

    always_comb begin
        // invert plus carry-in; product negation wins over addend negation
        term_p = s1.neg_p ? ~s1.prod : s1.prod;
        term_c = (!s1.neg_p && s1.neg_c) ? ~s1.addend : s1.addend;
        cin    = s1.po | s1.neg_p | s1.neg_c;
        sum    = term_p + term_c + {{(WIDE-1){1'b0}}, cin};

        case (s1.scl)
            SCL_SHA: shd = $signed(sum) >>> SH_A;
            SCL_SHB: shd = $signed(sum) >>> SH_B;
            default: shd = sum;
        endcase

        if (s1.sgn) begin
            over  = !shd[WIDE-1] && (|shd[WIDE-1:DW-1]);
            under =  shd[WIDE-1] && !(&shd[WIDE-1:DW-1]);
        end else begin
            over  = |shd[WIDE-1:DW];
            under = 1'b0;
        end

        if (s1.bad) begin
            res = '0;
        end else if (s1.sat && over) begin
            res = s1.sgn ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
        end else if (s1.sat && under) begin
            res = {1'b1, {(DW-1){1'b0}}};
        end else begin
            res = shd[DW-1:0];
        end
    end
endmodule

// File: rtl/imad_unit.sv
module imad_unit
    import imad_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   a_word,
    input  logic [DW-1:0]   b_word,
    input  logic [DW-1:0]   c_word,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic [SELW-1:0] a_sel,
    input  logic [SELW-1:0] b_sel,
    input  logic            a_neg,
    input  logic            b_neg,
    input  logic            c_neg,
    input  logic            plus_one,
    input  logic [1:0]      scale_mode,
    input  logic            sat_en,
    output logic            out_valid,
    output logic [DW-1:0]   out_result,
    output logic            out_illegal
);
    localparam int unsigned PADX = WIDE - XW;
    localparam int unsigned PADC = WIDE - DW;

    pipe_t           p_d;
    pipe_t           p_q;
    logic [XW-1:0]   ta;
    logic [XW-1:0]   tb;
    logic [WIDE-1:0] ta_w;
    logic [WIDE-1:0] tb_w;
    logic [DW-1:0]   fin_res;
    logic            neg_p;
    logic            sgn;

    imad_opsel u_sel_a (.word(a_word), .sgn(a_signed), .sel(a_sel), .ext(ta));
    imad_opsel u_sel_b (.word(b_word), .sgn(b_signed), .sel(b_sel), .ext(tb));
    imad_finish u_fin (.s1(p_q.s1), .res(fin_res));

    assign in_ready = 1'b1;

    always_comb begin
        p_d   = p_q;
        neg_p = a_neg ^ b_neg;
        sgn   = a_signed | b_signed | neg_p | c_neg;
        ta_w  = {{PADX{ta[XW-1]}}, ta};
        tb_w  = {{PADX{tb[XW-1]}}, tb};

        // stage one: full-width product and extended addend
        p_d.s1.vld    = in_valid & in_ready;
        p_d.s1.prod   = ta_w * tb_w;
        p_d.s1.addend = {{PADC{sgn & c_word[DW-1]}}, c_word};
        p_d.s1.neg_p  = neg_p;
        p_d.s1.neg_c  = c_neg;
        p_d.s1.po     = plus_one;
        p_d.s1.sgn    = sgn;
        p_d.s1.scl    = scale_e'(scale_mode);
        p_d.s1.sat    = sat_en;
        p_d.s1.bad    = plus_one & (a_neg | b_neg | c_neg);

        // stage two: sum, scale, clamp
        p_d.s2.vld = p_q.s1.vld;
        p_d.s2.res = fin_res;
        p_d.s2.bad = p_q.s1.bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid   = p_q.s2.vld;
    assign out_result  = p_q.s2.res;
    assign out_illegal = p_q.s2.bad;
endmodule

// File: rtl/imad_chk.sv
module imad_chk
    import imad_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] a_word,
    input logic [DW-1:0] c_word,
    input logic          a_neg,
    input logic          b_neg,
    input logic          c_neg,
    input logic          plus_one,
    input logic [1:0]    scale_mode,
    input logic          sat_en,
    input logic          out_valid,
    input logic [DW-1:0] out_result,
    input logic          out_illegal
);
    a_r9_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r9_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    a_r8_illegal_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && plus_one && (a_neg || b_neg || c_neg)) |-> ##2 out_illegal);

    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0));

    a_r5_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && plus_one && !(a_neg || b_neg || c_neg) && a_word == '0
         && scale_mode == 2'd0 && !sat_en)
        |-> ##2 (out_result == $past(c_word, 2) + 32'd1));
endmodule

bind imad_unit imad_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_word     (a_word),
    .c_word     (c_word),
    .a_neg      (a_neg),
    .b_neg      (b_neg),
    .c_neg      (c_neg),
    .plus_one   (plus_one),
    .scale_mode (scale_mode),
    .sat_en     (sat_en),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_illegal(out_illegal)
);

// File: tb/sim_imad_unit.sv
`timescale 1ns/1ps
module sim_imad_unit;
    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        as;
        logic        bs;
        logic [2:0]  asel;
        logic [2:0]  bsel;
        logic        an;
        logic        bn;
        logic        cn;
        logic        po;
        logic [1:0]  scl;
        logic        sat;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    stim_t       cur = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        v1 = 1'b0, v2 = 1'b0;
    logic [32:0] e1 = '0, e2 = '0;
    string       t1 = "", t2 = "";

    always #2 clk = ~clk;

    imad_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_word(cur.a), .b_word(cur.b), .c_word(cur.c),
        .a_signed(cur.as), .b_signed(cur.bs), .a_sel(cur.asel), .b_sel(cur.bsel),
        .a_neg(cur.an), .b_neg(cur.bn), .c_neg(cur.cn), .plus_one(cur.po),
        .scale_mode(cur.scl), .sat_en(cur.sat),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic signed [127:0] ext128(logic [31:0] w, logic sg, logic [2:0] sel);
        logic [7:0]  f8;
        logic [15:0] f16;
        if (sel < 3'd4) begin
            f8 = w[8*sel +: 8];
            return sg ? {{120{f8[7]}}, f8} : {120'd0, f8};
        end else if (sel < 3'd6) begin
            f16 = w[16*(sel-3'd4) +: 16];
            return sg ? {{112{f16[15]}}, f16} : {112'd0, f16};
        end
        return sg ? {{96{w[31]}}, w} : {96'd0, w};
    endfunction

    // returns {illegal, result}
    function automatic logic [32:0] model(stim_t s);
        logic signed [127:0] ta, tb, p, ce, sm, sh;
        logic negp, sg;
        if (s.po && (s.an || s.bn || s.cn)) return {1'b1, 32'd0};
        negp = s.an ^ s.bn;
        sg   = s.as | s.bs | negp | s.cn;
        ta = ext128(s.a, s.as, s.asel);
        tb = ext128(s.b, s.bs, s.bsel);
        p  = ta * tb;
        ce = sg ? {{96{s.c[31]}}, s.c} : {96'd0, s.c};
        if (negp)       sm = ce - p;
        else if (s.cn)  sm = p - ce;
        else            sm = p + ce + (s.po ? 128'sd1 : 128'sd0);
        if (s.scl == 2'd1)      sh = sm >>> 7;
        else if (s.scl == 2'd2) sh = sm >>> 15;
        else                    sh = sm;
        if (s.sat) begin
            if (sg) begin
                if (sh > 128'sd2147483647)  return {1'b0, 32'h7FFF_FFFF};
                if (sh < -128'sd2147483648) return {1'b0, 32'h8000_0000};
            end else begin
                if (sh > 128'sd4294967295)  return {1'b0, 32'hFFFF_FFFF};
                if (sh < 128'sd0)           return {1'b0, 32'h0000_0000};
            end
        end
        return {1'b0, sh[31:0]};
    endfunction

    function automatic stim_t mk(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                 logic as, logic bs, logic [2:0] asel, logic [2:0] bsel,
                                 logic an, logic bn, logic cn, logic po,
                                 logic [1:0] scl, logic sat);
        stim_t s;
        s.a = a; s.b = b; s.c = c; s.as = as; s.bs = bs; s.asel = asel; s.bsel = bsel;
        s.an = an; s.bn = bn; s.cn = cn; s.po = po; s.scl = scl; s.sat = sat;
        return s;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one falling edge: compare the slot queued two edges ago, then drive
    task automatic step(logic v, stim_t s, string tag);
        @(negedge clk);
        check("R9", "out_valid", {31'd0, out_valid}, {31'd0, v2});
        if (v2) begin
            check(t2, "result", out_result, e2[31:0]);
            check(t2 == "R8" ? "R8" : t2, "illegal", {31'd0, out_illegal}, {31'd0, e2[32]});
        end
        v2 = v1; e2 = e1; t2 = t1;
        v1 = v; e1 = model(s); t1 = tag;
        in_valid = v;
        cur = s;
    endtask

    function automatic string tag_of(stim_t s);
        if (s.po && (s.an || s.bn || s.cn)) return "R8";
        if (s.sat)          return "R7";
        if (s.scl != 2'd0)  return "R6";
        if (s.po)           return "R5";
        if (s.an ^ s.bn)    return "R2";
        if (s.cn)           return "R4";
        if (s.as | s.bs)    return "R3";
        return "R1";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        stim_t s;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R10", "out_result", out_result, 32'd0);
        check("R10", "out_illegal", {31'd0, out_illegal}, 32'd0);
        check("R9", "in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;

        // R1 sub-word selection and extension
        step(1, mk(32'h1122_3344, 32'd3, 32'd0, 0, 0, 3'd2, 3'd6, 0, 0, 0, 0, 2'd0, 0), "R1");
        step(1, mk(32'h0000_8001, 32'd1, 32'd0, 1, 1, 3'd4, 3'd7, 0, 0, 0, 0, 2'd0, 0), "R1");
        step(1, mk(32'h0000_0080, 32'd2, 32'd0, 1, 0, 3'd0, 3'd6, 0, 0, 0, 0, 2'd0, 0), "R1");
        step(1, mk(32'hABCD_0000, 32'h0000_0100, 32'd5, 0, 0, 3'd5, 3'd1, 0, 0, 0, 0, 2'd0, 0), "R1");
        step(1, mk(32'h8000_0000, 32'd1, 32'd0, 0, 0, 3'd3, 3'd6, 0, 0, 0, 0, 2'd0, 0), "R1");
        // R2 product negation, one flag and both flags
        step(1, mk(32'd5, 32'd3, 32'd20, 0, 0, 3'd6, 3'd6, 1, 0, 0, 0, 2'd0, 0), "R2");
        step(1, mk(32'd5, 32'd3, 32'd20, 0, 0, 3'd6, 3'd6, 1, 1, 0, 0, 2'd0, 0), "R2");
        step(0, '0, "R9");
        // R3 unsigned operands with negated addend become signed
        step(1, mk(32'd2, 32'd3, 32'd10, 0, 0, 3'd6, 3'd6, 0, 0, 1, 0, 2'd0, 1), "R3");
        step(1, mk(32'd2, 32'd3, 32'hFFFF_FFF0, 0, 0, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 1), "R3");
        step(1, mk(32'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 0, 1, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 1), "R3");
        // R4 addend negation, and ignored when product negated
        step(1, mk(32'd7, 32'd3, 32'd5, 0, 0, 3'd6, 3'd6, 0, 0, 1, 0, 2'd0, 0), "R4");
        step(1, mk(32'd2, 32'd3, 32'd10, 0, 0, 3'd6, 3'd6, 0, 1, 1, 0, 2'd0, 0), "R4");
        // R5 plus one
        step(1, mk(32'd3, 32'd3, 32'd4, 0, 0, 3'd6, 3'd6, 0, 0, 0, 1, 2'd0, 0), "R5");
        step(1, mk(32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 1, 1, 3'd6, 3'd6, 0, 0, 0, 1, 2'd1, 0), "R5");
        // R6 scaling, signed and unsigned fill, reserved code
        step(1, mk(32'hFFFE_7960, 32'd1000, 32'd0, 1, 1, 3'd6, 3'd6, 0, 0, 0, 0, 2'd2, 0), "R6");
        step(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0, 0, 3'd6, 3'd6, 0, 0, 0, 0, 2'd2, 0), "R6");
        step(1, mk(32'd1000, 32'd1000, 32'd0, 0, 0, 3'd6, 3'd6, 1, 0, 0, 0, 2'd1, 0), "R6");
        step(1, mk(32'd1000, 32'd1000, 32'd7, 0, 0, 3'd6, 3'd6, 0, 0, 0, 0, 2'd3, 0), "R6");
        // R7 saturation bounds and wrap without it
        step(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0, 0, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 1), "R7");
        step(1, mk(32'h7FFF_FFFF, 32'd2, 32'd0, 1, 1, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 1), "R7");
        step(1, mk(32'h8000_0000, 32'd2, 32'd0, 1, 1, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 1), "R7");
        step(1, mk(32'h8000_0000, 32'd2, 32'd0, 1, 1, 3'd6, 3'd6, 0, 0, 0, 0, 2'd0, 0), "R7");
        // R8 forbidden combination
        step(1, mk(32'd9, 32'd9, 32'd9, 0, 0, 3'd6, 3'd6, 1, 0, 0, 1, 2'd0, 0), "R8");
        step(1, mk(32'd9, 32'd9, 32'd9, 0, 0, 3'd6, 3'd6, 0, 0, 1, 1, 2'd0, 1), "R8");
        step(0, '0, "R9");
        step(0, '0, "R9");

        // constrained random mix with bubbles
        for (int i = 0; i < 4000; i++) begin
            logic v;
            s = stim_t'({$urandom, $urandom, $urandom, $urandom});
            if (s.po && ($urandom_range(0, 7) != 0)) begin
                s.an = 1'b0; s.bn = 1'b0; s.cn = 1'b0;
            end
            v = ($urandom_range(0, 4) != 0);
            step(v, s, tag_of(s));
        end
        step(0, '0, "R9");
        step(0, '0, "R9");
        step(0, '0, "R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule